// File: doc/BRIEF.md
# Serial Controller Interrupt Identifier

This block decides which interrupt a 16550-style serial controller reports and drives the controller's single interrupt line. It watches the line error flags, the receive data-ready flag, the receive FIFO fill level against its trigger threshold, a character-timeout flag, the modem-status change bits and the FIFO mode bit. It gates each of these with a four-bit enable register, picks the source with the highest priority, and presents the result as an 8-bit identification value.

The block holds two pieces of state. One is the enable register. The other is a hidden "transmitter holding register empty" pending flag. That flag is armed when the transmitter drains or when the enable register is written while the holding register is empty. It is dropped when new transmit data is written or when software reads the identification value. The identification value and the interrupt line are recomputed combinationally every cycle. The register decode, the shifters, the baud generator and the FIFO storage sit outside this block and drive its strobe and status inputs.

Top module: `uirq_ident`

## Requirements
- R1: The identification code in `iir[3:0]` follows a fixed priority, highest first:
  - line error, 0x6
  - character timeout, 0xC
  - receive data, 0x4
  - transmit empty, 0x2
  - modem change, 0x0
  - With no source active, the code is 0x1.
- R2: The line-error code is reported when enable bit 2 is 1 and any bit of `lsr_err` (overrun, parity, framing, break) is 1.
- R3: The character-timeout code is reported when `timeout_pend` is 1 and enable bit 0 is 1. No other enable bit can enable it.
- R4: The receive-data source is active when `data_ready` is 1 and enable bit 0 is 1, with one further condition. When `fifo_en` is 1, `rx_count` must also be greater than or equal to `rx_trig`.
- R5: The transmit-empty pending flag is set, cleared or held on each clock edge as follows:
  - A `thr_wr` pulse clears it, and this outranks every other event.
  - Otherwise a `tx_drained` pulse sets it, and so does an `ier_wr` pulse while `thre` is 1.
  - Otherwise an `iir_rd` pulse clears it.
  - With none of these events, it holds its value.
- R6: The transmit-empty code is reported when enable bit 1 is 1 and the pending flag is set.
- R7: The modem-change code is reported when enable bit 3 is 1 and any bit of `msr_delta` is 1.
- R8: `iir[7:6]` is 2'b11 while `fifo_en` is 1 and 2'b00 otherwise. `iir[5:4]` is always 0.
- R9: An `ier_wr` pulse stores `wr_data[3:0]` into the enable register, visible on `ier` from the next cycle. `wr_data[7:4]` is discarded.
- R10: `irq` is 1 exactly when `iir[3:0]` is not 0x1. It follows the inputs within the same cycle.
- R11: Reset clears the enable register and the pending flag, so `iir[3:0]` reads 0x1 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Strobe: write the enable register |
| wr_data | input | 8 | Write data for the enable register |
| thr_wr | input | 1 | Strobe: transmit holding register written |
| iir_rd | input | 1 | Strobe: identification value read |
| tx_drained | input | 1 | Strobe: transmitter became empty |
| thre | input | 1 | Holding register currently empty |
| lsr_err | input | 4 | Overrun, parity, framing and break flags |
| data_ready | input | 1 | Receive data available |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger threshold |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| fifo_en | input | 1 | FIFO mode enabled |
| ier | output | 4 | Stored enable register |
| iir | output | 8 | Interrupt identification value |
| irq | output | 1 | Level interrupt, active high |

## Verification
Some checks run on every cycle. The assertions check that an enabled line error always wins, and that an enabled modem change or timeout is reported when nothing above it is active. They also check the FIFO mode bits and the agreement between `irq` and the code. They check each update rule of the pending flag and the truncated store into the enable register.

Other behaviour only the bench scenarios can show. One case is the receive source staying silent below the trigger level and firing exactly at it. Another is the pending flag, which is visible only through the identification value, being dropped by a read and re-armed by an enable write. The last is the timeout being masked when only the other enables are set.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int IER_W     = 4;
    localparam int EN_RX     = 0;
    localparam int EN_TXE    = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1,
        ID_TXE     = 4'h2,
        ID_RXDATA  = 4'h4,
        ID_LINE    = 4'h6,
        ID_TIMEOUT = 4'hC
    } irq_id_e;

    typedef struct packed {
        logic [IER_W-1:0] ier;
        logic             txe_pend;
    } ctl_state_t;

endpackage

// File: rtl/uirq_ctl_state.sv
module uirq_ctl_state
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       wr_data,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             tx_drained,
    input  logic             thre,
    output logic [IER_W-1:0] ier_q,
    output logic             txe_pend_q
);

    ctl_state_t st_d, st_q;
    logic arm_evt;

    always_comb begin
        st_d    = st_q;
        arm_evt = tx_drained || (ier_wr && thre);
        if (ier_wr)
            st_d.ier = wr_data[IER_W-1:0];
        if (iir_rd)
            st_d.txe_pend = 1'b0;
        if (arm_evt)
            st_d.txe_pend = 1'b1;
        if (thr_wr)
            st_d.txe_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ier_q      = st_q.ier;
    assign txe_pend_q = st_q.txe_pend;

    assert_ier_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier_q == $past(wr_data[IER_W-1:0])));

    assert_thr_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !txe_pend_q);

    assert_drain_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_drained && !thr_wr) |=> txe_pend_q);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && !thr_wr && !tx_drained && !(ier_wr && thre)) |=> !txe_pend_q);

endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [IER_W-1:0] ier,
    input  logic [3:0]       lsr_err,
    input  logic             data_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             timeout_pend,
    input  logic             txe_pend,
    input  logic [3:0]       msr_delta,
    input  logic             fifo_en,
    output irq_id_e          id
);

    logic line_act, tmo_act, rx_act, txe_act, modem_act;

    always_comb begin
        line_act  = ier[EN_LINE] && (|lsr_err);
        tmo_act   = ier[EN_RX] && timeout_pend;
        rx_act    = ier[EN_RX] && data_ready && (!fifo_en || (rx_count >= rx_trig));
        txe_act   = ier[EN_TXE] && txe_pend;
        modem_act = ier[EN_MODEM] && (|msr_delta);

        if (line_act)
            id = ID_LINE;
        else if (tmo_act)
            id = ID_TIMEOUT;
        else if (rx_act)
            id = ID_RXDATA;
        else if (txe_act)
            id = ID_TXE;
        else if (modem_act)
            id = ID_MODEM;
        else
            id = ID_NONE;
    end

endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
    import uirq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       wr_data,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             tx_drained,
    input  logic             thre,
    input  logic [3:0]       lsr_err,
    input  logic             data_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             timeout_pend,
    input  logic [3:0]       msr_delta,
    input  logic             fifo_en,
    output logic [3:0]       ier,
    output logic [7:0]       iir,
    output logic             irq
);

    logic [IER_W-1:0] ier_q;
    logic             txe_pend_q;
    irq_id_e          id;

    uirq_ctl_state i_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ier_wr     (ier_wr),
        .wr_data    (wr_data),
        .thr_wr     (thr_wr),
        .iir_rd     (iir_rd),
        .tx_drained (tx_drained),
        .thre       (thre),
        .ier_q      (ier_q),
        .txe_pend_q (txe_pend_q)
    );

    uirq_prio_enc #(.CNT_W(CNT_W)) i_enc (
        .ier          (ier_q),
        .lsr_err      (lsr_err),
        .data_ready   (data_ready),
        .rx_count     (rx_count),
        .rx_trig      (rx_trig),
        .timeout_pend (timeout_pend),
        .txe_pend     (txe_pend_q),
        .msr_delta    (msr_delta),
        .fifo_en      (fifo_en),
        .id           (id)
    );

    always_comb begin
        iir = {{2{fifo_en}}, 2'b00, id};
        irq = (id != ID_NONE);
    end

    assign ier = ier_q;

    assert_line_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && (|lsr_err)) |-> (iir[3:0] == 4'h6));

    assert_timeout_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[0] && timeout_pend && !(ier[2] && (|lsr_err))) |-> (iir[3:0] == 4'hC));

    assert_modem_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[3] && (|msr_delta)) |-> irq);

    assert_fifo_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iir[7:4] == (fifo_en ? 4'hC : 4'h0));

    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir[3:0] != 4'h1));

    assert_quiet_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'h0) |-> (!irq && iir[3:0] == 4'h1));

endmodule

// File: tb/test_uirq_ident.sv
module test_uirq_ident;

    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ier_wr = 0, thr_wr = 0, iir_rd = 0, tx_drained = 0, thre = 0;
    logic [7:0]    wr_data = 0;
    logic [3:0]    lsr_err = 0, msr_delta = 0;
    logic          data_ready = 0, timeout_pend = 0, fifo_en = 0;
    logic [CW-1:0] rx_count = 0, rx_trig = 0;
    logic [3:0]    ier;
    logic [7:0]    iir;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    logic [3:0] ier_m = 0;
    logic       pend_m = 0;

    always #4 clk = ~clk;

    uirq_ident i_uirq_ident (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .wr_data(wr_data),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .tx_drained(tx_drained), .thre(thre),
        .lsr_err(lsr_err), .data_ready(data_ready), .rx_count(rx_count),
        .rx_trig(rx_trig), .timeout_pend(timeout_pend), .msr_delta(msr_delta),
        .fifo_en(fifo_en), .ier(ier), .iir(iir), .irq(irq)
    );

    function automatic logic [7:0] exp_iir();
        logic [3:0] id;
        id = 4'h1;
        if (ier_m[2] && |lsr_err) id = 4'h6;
        else if (ier_m[0] && timeout_pend) id = 4'hC;
        else if (ier_m[0] && data_ready && (!fifo_en || rx_count >= rx_trig)) id = 4'h4;
        else if (ier_m[1] && pend_m) id = 4'h2;
        else if (ier_m[3] && |msr_delta) id = 4'h0;
        return {fifo_en, fifo_en, 2'b00, id};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [7:0] e;
        @(negedge clk);
        #1;
        e = exp_iir();
        check(iir == e, {tag, " iir"}, iir, e);
        check(irq == (e[3:0] != 4'h1), {tag, " irq R10"}, irq, e[3:0] != 4'h1);
        check(ier == ier_m, {tag, " ier R9"}, ier, ier_m);
        @(posedge clk);
        if (ier_wr) ier_m = wr_data[3:0];
        if (iir_rd) pend_m = 0;
        if (tx_drained || (ier_wr && thre)) pend_m = 1;
        if (thr_wr) pend_m = 0;
        #1;
    endtask

    task automatic clr_strobes();
        ier_wr = 0; thr_wr = 0; iir_rd = 0; tx_drained = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog R1 actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd77));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step("R11 reset");
        ier_wr = 1; wr_data = 8'hF2; thre = 0;
        step("R9 upper bits");
        clr_strobes();
        step("R11 pending clear after reset");
        tx_drained = 1;
        step("R5 drain");
        clr_strobes();
        step("R6 txe code");
        iir_rd = 1;
        step("R5 read");
        clr_strobes();
        step("R5 read clears");
        ier_wr = 1; wr_data = 8'h02; thre = 1;
        step("R5 rearm write");
        clr_strobes();
        step("R5 ier rearm");
        thr_wr = 1; tx_drained = 1;
        step("R5 thr vs drain");
        clr_strobes();
        step("R5 thr write wins");
        ier_wr = 1; wr_data = 8'h0D; thre = 0;
        step("R9 write");
        clr_strobes();
        fifo_en = 1; data_ready = 1; rx_count = 3; rx_trig = 4;
        step("R4 below trigger");
        rx_count = 4;
        step("R4 at trigger R8");
        fifo_en = 0; rx_count = 0;
        step("R4 fifo off");
        timeout_pend = 1;
        step("R3 timeout");
        lsr_err = 4'b0100;
        step("R2 line");
        lsr_err = 0; timeout_pend = 0; data_ready = 0; msr_delta = 4'b0001;
        step("R7 modem");
        ier_wr = 1; wr_data = 8'h0C;
        step("R9 write");
        clr_strobes();
        timeout_pend = 1; data_ready = 1;
        step("R3 gated by rx enable");
        for (int i = 0; i < 3000; i++) begin
            ier_wr     = ($urandom % 4) == 0;
            wr_data    = 8'($urandom);
            thr_wr     = ($urandom % 6) == 0;
            iir_rd     = ($urandom % 5) == 0;
            tx_drained = ($urandom % 5) == 0;
            thre       = 1'($urandom);
            lsr_err    = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            data_ready = 1'($urandom);
            rx_count   = CW'($urandom % 17);
            case ($urandom % 4)
                0: rx_trig = 1;
                1: rx_trig = 4;
                2: rx_trig = 8;
                default: rx_trig = 14;
            endcase
            timeout_pend = ($urandom % 4) == 0;
            msr_delta  = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
            fifo_en    = 1'($urandom);
            step("R1 R5 R8 random");
        end
        finish_run();
    end

endmodule